// File: doc/BRIEF.md
# Four-Level Page Table Walker

The walker translates a 64-bit virtual address into a 52-bit physical address. It reads a four-level radix tree of 512-entry tables held in memory, starting from a root table given by a frame number input. Each request carries the access attributes: write, instruction fetch and user mode. The walker returns the physical address, the page size, a fault code and the table level at which the walk stopped.

The walker issues one 64-bit entry read per level over a simple memory port. That port has a single outstanding access: the request is held until an acknowledge arrives. Walks can end early on a large-page entry at the two middle levels. Permission bits are combined over every level visited. When the access is allowed, the walker sets the accessed and dirty flags in the leaf entry with a read-modify-write before it responds. Only one walk is in progress at a time, and `req_ready_o` holds off new requests until then.

Top module: `pt_walker`

## Requirements
- R1: Bits 63:47 of the virtual address must all be equal. If they are not, the response has fault code 1, level 0, physical address 0, and no memory access is made.
- R2: At level L (4 down to 1), the table index is virtual address bits [12+9(L-1)+8 : 12+9(L-1)]. The entry is read from byte address {table frame number, index, 3'b000}. Level 4 uses `root_pfn_i`. Every lower table uses bits 51:12 of the entry above it. A walk makes exactly one read per level visited, and the address is held stable until the read is acknowledged.
- R3: An entry read with bit 0 clear ends the walk with fault code 2 and reports that level.
- R4: An entry with bit 7 set at level 2 ends the walk with size code 1 (2 MiB), keeping 21 offset bits. At level 3 it gives size code 2 (1 GiB), keeping 30 offset bits. Bit 7 set at level 4 or level 1 gives fault code 3 at that level.
- R5: A level 1 leaf gives size code 0. The physical address is {entry bits 51:12, virtual address bits 11:0}, and the level reported is 1.
- R6: Writable (bit 1) and user (bit 2) are ANDed over all levels visited. A write without the effective writable bit, or a user access without the effective user bit, gives fault code 4 at the leaf level.
- R7: No-execute (bit 63) is ORed over all levels visited. It faults an instruction fetch with code 4 only while `nxe_i` is high. While `nxe_i` is low, it has no effect.
- R8: On success, the walker writes back the leaf entry with bit 5 set, and also bit 6 on a write, to the same address before responding. The write is skipped when those bits are already set. No write is made on a fault.
- R9: `req_ready_o` is low from acceptance until the response. `rsp_valid_o` is a one-cycle pulse, and exactly one response is given per accepted request.
- R10: During and right after reset, `req_ready_o` is high and `mem_req_o` and `rsp_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request |
| req_ready_o | output | 1 | Walker idle, request accepted |
| req_va_i | input | 64 | Virtual address |
| req_wr_i | input | 1 | Access is a write |
| req_ex_i | input | 1 | Access is an instruction fetch |
| req_user_i | input | 1 | Access is from user mode |
| nxe_i | input | 1 | Enforce the no-execute bit |
| root_pfn_i | input | 40 | Frame number of the level 4 table |
| mem_req_o | output | 1 | Memory access pending |
| mem_we_o | output | 1 | Pending access is a write |
| mem_addr_o | output | 52 | Entry byte address |
| mem_wdata_o | output | 64 | Updated entry for write-back |
| mem_ack_i | input | 1 | Access done; read data valid |
| mem_rdata_i | input | 64 | Entry read data |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_pa_o | output | 52 | Physical address (0 on fault) |
| rsp_size_o | output | 2 | 0: 4 KiB, 1: 2 MiB, 2: 1 GiB |
| rsp_fault_o | output | 3 | 0 none, 1 non-canonical, 2 not present, 3 reserved bit, 4 permission |
| rsp_level_o | output | 3 | Level where the walk ended |

## Verification
A corrupted level counter or table base shows up at the memory port first. The next entry read goes to the wrong address or there is one read too many or too few, which the bench counts for every walk. A bad permission accumulator or large-page decode appears in the response of that same walk as a wrong fault code, size or address. A faulty update decision shows up as an extra or missing write, or as a wrong value left in the bench memory before the response pulse.

// File: rtl/pw_pkg.sv
`timescale 1ns/1ps
package pw_pkg;
  localparam int VA_W   = 48;
  localparam int PA_W   = 52;
  localparam int OFF_W  = 12;
  localparam int IDX_W  = 9;
  localparam int LVLS   = 4;
  localparam int LVL_W  = $clog2(LVLS + 1);
  localparam int PFN_W  = PA_W - OFF_W;

  localparam int B_PRES = 0;
  localparam int B_WR   = 1;
  localparam int B_USR  = 2;
  localparam int B_ACC  = 5;
  localparam int B_DRT  = 6;
  localparam int B_BIG  = 7;
  localparam int B_NX   = 63;

  typedef enum logic [2:0] {
    FLT_NONE  = 3'd0,
    FLT_CANON = 3'd1,
    FLT_NP    = 3'd2,
    FLT_RSVD  = 3'd3,
    FLT_PERM  = 3'd4
  } fault_e;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR, ST_RSP} walk_st_e;
endpackage

// File: rtl/pw_index.sv
`timescale 1ns/1ps
module pw_index
  import pw_pkg::*;
(
  input  logic [VA_W-1:0]  va_i,
  input  logic [LVL_W-1:0] lvl_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] slice [LVLS];

  for (genvar g = 0; g < LVLS; g++) begin : g_lvl
    assign slice[g] = va_i[OFF_W + IDX_W*g +: IDX_W];
  end

  always_comb begin
    idx_o = '0;
    for (int l = 1; l <= LVLS; l++)
      if (lvl_i == LVL_W'(l)) idx_o = slice[l-1];
  end
endmodule

// File: rtl/pw_entry_eval.sv
`timescale 1ns/1ps
module pw_entry_eval
  import pw_pkg::*;
(
  input  logic [63:0]      entry_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic             acc_w_i,
  input  logic             acc_u_i,
  input  logic             acc_nx_i,
  input  logic             wr_i,
  input  logic             ex_i,
  input  logic             us_i,
  input  logic             nxe_i,
  output logic             stop_o,
  output fault_e           fault_o,
  output logic [1:0]       size_o,
  output logic             w_o,
  output logic             u_o,
  output logic             nx_o,
  output logic             upd_o,
  output logic [63:0]      upd_val_o
);
  logic big_ok, leaf, deny;

  always_comb begin
    w_o    = acc_w_i & entry_i[B_WR];
    u_o    = acc_u_i & entry_i[B_USR];
    nx_o   = acc_nx_i | entry_i[B_NX];
    big_ok = (lvl_i >= LVL_W'(2)) && (lvl_i < LVL_W'(LVLS));
    leaf   = (lvl_i == LVL_W'(1)) || (entry_i[B_BIG] && big_ok);
    deny   = (wr_i & ~w_o) | (us_i & ~u_o) | (ex_i & nxe_i & nx_o);
    size_o = leaf ? 2'(lvl_i - LVL_W'(1)) : 2'd0;

    fault_o = FLT_NONE;
    if (!entry_i[B_PRES])                fault_o = FLT_NP;
    else if (entry_i[B_BIG] && !big_ok)  fault_o = FLT_RSVD;
    else if (leaf && deny)               fault_o = FLT_PERM;
    stop_o = leaf || (fault_o != FLT_NONE);

    upd_val_o = entry_i;
    upd_val_o[B_ACC] = 1'b1;
    if (wr_i) upd_val_o[B_DRT] = 1'b1;
    upd_o = (upd_val_o != entry_i);
  end
endmodule

// File: rtl/pt_walker.sv
`timescale 1ns/1ps
module pt_walker
  import pw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [63:0]       req_va_i,
  input  logic              req_wr_i,
  input  logic              req_ex_i,
  input  logic              req_user_i,
  input  logic              nxe_i,
  input  logic [PFN_W-1:0]  root_pfn_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [PA_W-1:0]   mem_addr_o,
  output logic [63:0]       mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [63:0]       mem_rdata_i,
  output logic              rsp_valid_o,
  output logic [PA_W-1:0]   rsp_pa_o,
  output logic [1:0]        rsp_size_o,
  output logic [2:0]        rsp_fault_o,
  output logic [2:0]        rsp_level_o
);
  walk_st_e         st_q;
  logic [VA_W-1:0]  va_q;
  logic             wr_q, ex_q, us_q, nxe_q;
  logic [LVL_W-1:0] lvl_q;
  logic [PFN_W-1:0] base_q;
  logic             acc_w_q, acc_u_q, acc_nx_q;
  logic [63:0]      wdata_q;
  logic [PA_W-1:0]  pa_q;
  logic [1:0]       sz_q;
  fault_e           flt_q;
  logic [2:0]       lvl_rsp_q;

  logic [IDX_W-1:0] idx;
  logic             ev_stop, ev_w, ev_u, ev_nx, ev_upd;
  fault_e           ev_fault;
  logic [1:0]       ev_size;
  logic [63:0]      ev_upd_val;
  logic [PA_W-1:0]  pa_mask, leaf_pa;
  logic [63:VA_W-1] va_top;
  logic             canon;

  pw_index u_idx (.va_i(va_q), .lvl_i(lvl_q), .idx_o(idx));

  pw_entry_eval u_eval (
    .entry_i(mem_rdata_i), .lvl_i(lvl_q),
    .acc_w_i(acc_w_q), .acc_u_i(acc_u_q), .acc_nx_i(acc_nx_q),
    .wr_i(wr_q), .ex_i(ex_q), .us_i(us_q), .nxe_i(nxe_q),
    .stop_o(ev_stop), .fault_o(ev_fault), .size_o(ev_size),
    .w_o(ev_w), .u_o(ev_u), .nx_o(ev_nx),
    .upd_o(ev_upd), .upd_val_o(ev_upd_val)
  );

  assign va_top = req_va_i[63:VA_W-1];
  assign canon  = (&va_top) | ~(|va_top);

  // offset bits kept from the VA grow by one index width per level
  always_comb begin
    pa_mask = (PA_W'(1) << (OFF_W + IDX_W*(int'(lvl_q) - 1))) - PA_W'(1);
    leaf_pa = (mem_rdata_i[PA_W-1:0] & ~pa_mask) | (PA_W'(va_q) & pa_mask);
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign mem_req_o   = (st_q == ST_RD) || (st_q == ST_WR);
  assign mem_we_o    = (st_q == ST_WR);
  assign mem_addr_o  = {base_q, idx, 3'b000};
  assign mem_wdata_o = wdata_q;
  assign rsp_valid_o = (st_q == ST_RSP);
  assign rsp_pa_o    = pa_q;
  assign rsp_size_o  = sz_q;
  assign rsp_fault_o = flt_q;
  assign rsp_level_o = lvl_rsp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
      va_q <= '0;
      {wr_q, ex_q, us_q, nxe_q} <= '0;
      lvl_q <= '0;
      base_q <= '0;
      {acc_w_q, acc_u_q, acc_nx_q} <= 3'b110;
      wdata_q <= '0;
      pa_q <= '0;
      sz_q <= '0;
      flt_q <= FLT_NONE;
      lvl_rsp_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (req_valid_i) begin
          va_q  <= req_va_i[VA_W-1:0];
          wr_q  <= req_wr_i;
          ex_q  <= req_ex_i;
          us_q  <= req_user_i;
          nxe_q <= nxe_i;
          if (!canon) begin
            st_q      <= ST_RSP;
            flt_q     <= FLT_CANON;
            lvl_rsp_q <= '0;
            pa_q      <= '0;
            sz_q      <= '0;
          end else begin
            st_q   <= ST_RD;
            lvl_q  <= LVL_W'(LVLS);
            base_q <= root_pfn_i;
            {acc_w_q, acc_u_q, acc_nx_q} <= 3'b110;
          end
        end
        ST_RD: if (mem_ack_i) begin
          if (ev_stop) begin
            flt_q     <= ev_fault;
            lvl_rsp_q <= 3'(lvl_q);
            if (ev_fault == FLT_NONE) begin
              pa_q    <= leaf_pa;
              sz_q    <= ev_size;
              wdata_q <= ev_upd_val;
              st_q    <= ev_upd ? ST_WR : ST_RSP;
            end else begin
              pa_q <= '0;
              sz_q <= '0;
              st_q <= ST_RSP;
            end
          end else begin
            base_q   <= mem_rdata_i[PA_W-1:OFF_W];
            lvl_q    <= lvl_q - LVL_W'(1);
            acc_w_q  <= ev_w;
            acc_u_q  <= ev_u;
            acc_nx_q <= ev_nx;
          end
        end
        ST_WR:  if (mem_ack_i) st_q <= ST_RSP;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R1
  noncanon_no_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && !((&req_va_i[63:VA_W-1]) || !(|req_va_i[63:VA_W-1])))
    |=> (rsp_valid_o && !mem_req_o && rsp_fault_o == 3'(FLT_CANON)));

  // R2
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  // R4
  big_no_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_size_o != 2'd0) |-> (rsp_fault_o == 3'(FLT_NONE) && rsp_level_o > 3'd1));

  // R8
  wb_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_req_o && mem_wdata_o[B_ACC] && mem_wdata_o[B_PRES]));

  // R9
  busy_not_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o || rsp_valid_o) |-> !req_ready_o);

  // R9
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> (!rsp_valid_o && req_ready_o));
endmodule

// File: tb/sim_pt_walker.sv
`timescale 1ns/1ps
module sim_pt_walker;
  import pw_pkg::*;

  localparam logic [63:0] F_P = 64'h1, F_W = 64'h2, F_U = 64'h4, F_A = 64'h20,
                          F_D = 64'h40, F_PS = 64'h80, F_NX = 64'h8000_0000_0000_0000;
  localparam logic [63:0] F_RWU = F_P | F_W | F_U;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        req_valid = 1'b0, req_wr = 1'b0, req_ex = 1'b0, req_user = 1'b0, nxe = 1'b1;
  logic [63:0] req_va = '0;
  logic [51:0] root = 52'h5000;
  logic        req_ready, mem_req, mem_we, rsp_valid;
  logic [51:0] mem_addr, rsp_pa;
  logic [63:0] mem_wdata;
  logic        ack = 1'b0;
  logic [63:0] rdata = '0;
  logic [1:0]  rsp_size;
  logic [2:0]  rsp_fault, rsp_level;

  int checks = 0, errors = 0;
  int nrd = 0, nwr = 0, lat = 0, lat_cnt = 0;
  logic [63:0] mem [logic [51:0]];
  logic [51:0] next_pg = 52'h10_0000;
  logic [2:0]  last_flt;

  pt_walker u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_va_i(req_va),
    .req_wr_i(req_wr), .req_ex_i(req_ex), .req_user_i(req_user),
    .nxe_i(nxe), .root_pfn_i(root[51:12]),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ack_i(ack), .mem_rdata_i(rdata),
    .rsp_valid_o(rsp_valid), .rsp_pa_o(rsp_pa), .rsp_size_o(rsp_size),
    .rsp_fault_o(rsp_fault), .rsp_level_o(rsp_level)
  );

  // memory model: random latency 0..2, one access at a time
  always @(negedge clk) begin
    if (ack) begin
      ack = 1'b0;
      lat_cnt = 0;
    end else if (mem_req) begin
      if (lat_cnt >= lat) begin
        ack = 1'b1;
        if (mem_we) begin
          mem[mem_addr] = mem_wdata;
          nwr++;
        end else begin
          rdata = mem.exists(mem_addr) ? mem[mem_addr] : 64'h0;
          nrd++;
        end
        lat = $urandom_range(0, 2);
      end else lat_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] rd(input logic [51:0] a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  function automatic logic [63:0] mkva(input int a, input int b, input int c, input int d, input int off);
    logic [47:0] v;
    v = {9'(a), 9'(b), 9'(c), 9'(d), 12'(off)};
    return {{16{v[47]}}, v};
  endfunction

  function automatic string tag_of(input logic [2:0] f, input logic [1:0] s);
    case (f)
      3'd1: return "R1";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R6";
      default: return (s == 2'd0) ? "R5" : "R4";
    endcase
  endfunction

  task automatic ref_walk(input logic [63:0] va, input logic wr, input logic ex, input logic us,
                          input logic nx_en, output logic [51:0] pa, output logic [1:0] sz,
                          output logic [2:0] flt, output logic [2:0] lv, output int reads,
                          output bit upd, output logic [51:0] ua, output logic [63:0] uv);
    logic [51:0] b, a, m;
    logic [63:0] e;
    logic w, u, x;
    pa = '0; sz = '0; flt = 3'd0; lv = 3'd0; reads = 0; upd = 0; ua = '0; uv = '0;
    if (!((&va[63:47]) || !(|va[63:47]))) begin
      flt = 3'd1;
      return;
    end
    b = root; w = 1; u = 1; x = 0;
    for (int l = 4; l >= 1; l--) begin
      a = {b[51:12], va[12 + 9*(l-1) +: 9], 3'b000};
      e = rd(a);
      reads++;
      w &= e[1]; u &= e[2]; x |= e[63];
      lv = 3'(l);
      if (!e[0]) begin flt = 3'd2; return; end
      if (e[7] && (l == 4 || l == 1)) begin flt = 3'd3; return; end
      if (l == 1 || e[7]) begin
        if ((wr && !w) || (us && !u) || (ex && nx_en && x)) begin flt = 3'd4; return; end
        m  = (52'h1 << (12 + 9*(l-1))) - 52'h1;
        pa = (e[51:0] & ~m) | (va[51:0] & m);
        sz = 2'(l - 1);
        uv = e | F_A | (wr ? F_D : 64'h0);
        ua = a;
        upd = (uv != e);
        return;
      end
      b = e[51:0] & ~52'hFFF;
    end
  endtask

  task automatic chain(input logic [63:0] va, input int leaf, input logic [63:0] f4, input logic [63:0] f3,
                       input logic [63:0] f2, input logic [63:0] f1, input logic [51:0] frame);
    logic [51:0] b, a, nxt;
    logic [63:0] f;
    b = root;
    for (int l = 4; l >= leaf; l--) begin
      f = (l == 4) ? f4 : (l == 3) ? f3 : (l == 2) ? f2 : f1;
      a = {b[51:12], va[12 + 9*(l-1) +: 9], 3'b000};
      if (l == leaf) mem[a] = ({12'h0, frame} & 64'h000F_FFFF_FFFF_F000) | f;
      else begin
        nxt = next_pg;
        next_pg += 52'h1000;
        mem[a] = {12'h0, nxt} | f;
        b = nxt;
      end
    end
  endtask

  task automatic do_walk(input logic [63:0] va, input logic wr, input logic ex, input logic us);
    logic [51:0] e_pa, e_ua;
    logic [1:0]  e_sz;
    logic [2:0]  e_flt, e_lv;
    logic [63:0] e_uv;
    int e_rd, to;
    bit e_upd;
    string tg;
    ref_walk(va, wr, ex, us, nxe, e_pa, e_sz, e_flt, e_lv, e_rd, e_upd, e_ua, e_uv);
    tg = tag_of(e_flt, e_sz);
    @(negedge clk);
    nrd = 0; nwr = 0;
    req_va = va; req_wr = wr; req_ex = ex; req_user = us; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R9", "ready while busy", 64'(req_ready), 64'h0);
    to = 0;
    while (!rsp_valid && to < 200) begin
      @(negedge clk);
      to++;
    end
    last_flt = rsp_fault;
    chk(rsp_fault == e_flt, tg, "fault", 64'(rsp_fault), 64'(e_flt));
    chk(rsp_level == e_lv, tg, "level", 64'(rsp_level), 64'(e_lv));
    if (e_flt == 3'd0) begin
      chk(rsp_pa == e_pa, tg, "pa", 64'(rsp_pa), 64'(e_pa));
      chk(rsp_size == e_sz, tg, "size", 64'(rsp_size), 64'(e_sz));
    end
    chk(nrd == e_rd, (e_flt == 3'd1) ? "R1" : "R2", "reads", 64'(nrd), 64'(e_rd));
    chk(nwr == int'(e_upd), "R8", "writes", 64'(nwr), 64'(e_upd));
    if (e_upd) chk(rd(e_ua) == e_uv, "R8", "entry after update", rd(e_ua), e_uv);
    @(negedge clk);
    chk(req_ready && !rsp_valid, "R9", "idle after response", 64'({req_ready, rsp_valid}), 64'h2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] va;
    process::self().srandom(32'd1234);
    repeat (3) @(negedge clk);
    // R10
    chk(req_ready && !mem_req && !rsp_valid, "R10", "in reset", 64'({req_ready, mem_req, rsp_valid}), 64'h4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !mem_req && !rsp_valid, "R10", "after reset", 64'({req_ready, mem_req, rsp_valid}), 64'h4);

    // R5 / R8: 4 KiB leaf, accessed then dirty, then skipped writes
    va = mkva(1, 0, 511, 127, 12'h5ce);
    chain(va, 1, F_RWU, F_RWU, F_RWU, F_RWU, 52'hC000);
    do_walk(va, 0, 0, 0);
    do_walk(va, 0, 0, 0);
    do_walk(va, 1, 0, 0);
    do_walk(va, 1, 0, 0);

    // R4: 2 MiB and 1 GiB leaves
    va = mkva(2, 5, 9, 300, 12'h234);
    chain(va, 2, F_RWU, F_RWU, F_RWU | F_PS, 64'h0, 52'h7_4020_0000);
    do_walk(va, 1, 0, 0);
    va = mkva(3, 7, 257, 44, 12'habc);
    chain(va, 3, F_RWU, F_RWU | F_PS | F_A | F_D, 64'h0, 64'h0, 52'h3_4000_0000);
    do_walk(va, 1, 0, 0);

    // R3: not present at level 3
    va = mkva(4, 1, 1, 1, 0);
    chain(va, 1, F_RWU, F_W | F_U, F_RWU, F_RWU, 52'h9000);
    do_walk(va, 0, 0, 0);

    // R4: big bit at level 4 and at level 1
    va = mkva(5, 1, 1, 1, 0);
    chain(va, 1, F_RWU | F_PS, F_RWU, F_RWU, F_RWU, 52'h9000);
    do_walk(va, 0, 0, 0);
    va = mkva(6, 1, 1, 1, 0);
    chain(va, 1, F_RWU, F_RWU, F_RWU, F_RWU | F_PS, 52'h9000);
    do_walk(va, 0, 0, 0);

    // R6: write blocked at level 3, user blocked at level 2
    va = mkva(7, 2, 3, 4, 12'h10);
    chain(va, 1, F_RWU, F_P | F_U, F_RWU, F_RWU, 52'hA000);
    do_walk(va, 1, 0, 0);
    do_walk(va, 0, 0, 1);
    va = mkva(8, 2, 3, 4, 12'h20);
    chain(va, 1, F_RWU, F_RWU, F_P | F_W, F_RWU, 52'hB000);
    do_walk(va, 0, 0, 1);
    do_walk(va, 1, 0, 0);

    // R7: no-execute at level 4, with and without enforcement
    va = mkva(9, 2, 3, 4, 12'h30);
    chain(va, 1, F_RWU | F_NX, F_RWU, F_RWU, F_RWU, 52'hD000);
    nxe = 1'b1;
    do_walk(va, 0, 1, 0);
    chk(last_flt == 3'd4, "R7", "nx enforced", 64'(last_flt), 64'd4);
    nxe = 1'b0;
    do_walk(va, 0, 1, 0);
    chk(last_flt == 3'd0, "R7", "nx ignored", 64'(last_flt), 64'd0);
    nxe = 1'b1;

    // R1: non-canonical, then canonical upper half
    do_walk(64'h0001_0000_0000_0000, 0, 0, 0);
    do_walk(64'h7FFF_8000_0000_0000, 1, 0, 0);
    va = mkva(300, 4, 4, 4, 12'h44);
    chain(va, 1, F_RWU, F_RWU, F_RWU, F_RWU, 52'hE000);
    do_walk(va, 0, 0, 0);

    // random mix
    for (int it = 0; it < 300; it++) begin
      logic [63:0] f [4];
      int leaf;
      logic [51:0] fr;
      va = mkva($urandom_range(0, 511), $urandom_range(0, 511), $urandom_range(0, 511),
                $urandom_range(0, 511), $urandom_range(0, 4095));
      case ($urandom_range(0, 7))
        0: leaf = 3;
        1: leaf = 2;
        default: leaf = 1;
      endcase
      for (int l = 1; l <= 4; l++) begin
        f[l-1] = 64'h0;
        if ($urandom_range(0, 15) != 0) f[l-1] |= F_P;
        if ($urandom_range(0, 3) != 0)  f[l-1] |= F_W;
        if ($urandom_range(0, 3) != 0)  f[l-1] |= F_U;
        if ($urandom_range(0, 3) == 0)  f[l-1] |= F_NX;
        if ($urandom_range(0, 1) == 0)  f[l-1] |= F_A;
        if ($urandom_range(0, 1) == 0)  f[l-1] |= F_D;
        if (l == leaf && leaf > 1) f[l-1] |= F_PS;
        else if ($urandom_range(0, 31) == 0) f[l-1] |= F_PS;
      end
      fr = {$urandom(), $urandom()};
      chain(va, leaf, f[3], f[2], f[1], f[0], fr);
      if ($urandom_range(0, 15) == 0) va[62] = ~va[62];
      nxe = 1'($urandom_range(0, 1));
      do_walk(va, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule